// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Masked Register Writes

This block controls one port of eight general-purpose I/O pins through a 32-bit register interface. For each pin it holds a GPIO-mode enable, an output enable and an output value, and it drives the pad output enable only for pins that have both enables set. The input pins pass through a two-flop synchronizer. Their synchronized values can be read back, and they feed a per-pin interrupt detector. Each pin's trigger can be set to rising edge, falling edge, both edges, level high or level low.

Interrupt status bits collect the detected events. Software clears them through a write-one-to-clear register, and a per-pin enable mask gates them onto a single port interrupt line. For edge-type pins the status bit is sticky, and an edge that lands on or after the clear is not lost. For level-type pins the status bit follows the qualified level.

Every writable register also has a masked alias at a fixed upper offset. A write there carries a per-pin mask in bits [15:8] and the new values in bits [7:0], so software can change a single pin without a read-modify-write.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero, `pin_oe` is 0x00 and `port_irq` is 0.
- R2: Plain registers are word-aligned at these offsets: mode enable 0x00, output enable 0x10, output value 0x20, synchronized inputs 0x30, interrupt status 0x40, interrupt enable 0x50, trigger type 0x60 and status clear 0x70. The 8-bit registers read back in bits [7:0], and the trigger-type register reads back its 24 bits. Reads of the clear register, of any masked alias and of any unmapped offset return zero, and writes to unmapped offsets change nothing.
- R3: The masked alias of a register sits at its plain offset plus 0x80, for all registers except the inputs and the clear register. A masked write updates register bit n to wdata[n] only where wdata[8+n] is 1. For the trigger-type register, a masked write reaches only the polarity bits [7:0].
- R4: `pin_oe[n]` equals mode-enable bit n AND output-enable bit n, and `pin_out` equals the output-value register.
- R5: `pin_in` is double-synchronized. A change is visible at offset 0x30 after the second rising clock edge, and not after the first.
- R6: In the trigger-type register, bit n is the polarity for pin n (high or rising), bit 8+n selects edge mode and bit 16+n selects both edges. The codes {bit16+n, bit8+n, bit n} are 011 for rising, 010 for falling, 11x for both edges, 001 for level high and 000 for level low. A pin change shows up in the status register after the third rising clock edge.
- R7: Writing 1 to bit n of the clear register clears status bit n of an edge-type pin. Writing 0 has no effect.
- R8: An edge that is registered in the same cycle as a clear of its pin, or in any later cycle, sets the status bit again.
- R9: The status bit of a level-type pin follows the synchronized level matched against the polarity bit. A clear while the level is still active leaves the bit set.
- R10: `port_irq` is the OR over all pins of (status AND enable), and it follows a change of the enable register in the cycle after the write.
- R11: Plain and masked writes to the status register set or clear the status bits of edge-type pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Input pin levels, asynchronous |
| pin_out | output | 8 | Output pin values |
| pin_oe | output | 8 | Per-pin output enable |
| port_irq | output | 1 | Port interrupt request |

## Verification
Register writes take effect at the rising edge that samples the strobe, so reads, `pin_oe`, `pin_out` and `port_irq` are checked at the falling edge that follows. A pin change is checked one cycle early and then exactly on its due cycle: the input register after two rising edges and the status register after three. The clear-collision case raises the write strobe across the third edge after the pin change, so the edge event and the clear are registered in the same cycle. Configuration sweeps cover all 256 enable patterns, and each trigger code is driven through rise, clear and fall.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int REG_W = 32;

    // register index = address bits [6:4]
    localparam logic [2:0] IDX_CNF = 3'd0;
    localparam logic [2:0] IDX_OE  = 3'd1;
    localparam logic [2:0] IDX_OUT = 3'd2;
    localparam logic [2:0] IDX_IN  = 3'd3;
    localparam logic [2:0] IDX_STA = 3'd4;
    localparam logic [2:0] IDX_ENB = 3'd5;
    localparam logic [2:0] IDX_LVL = 3'd6;
    localparam logic [2:0] IDX_CLR = 3'd7;

    // byte lanes of the trigger-type register and of a masked write
    localparam int LANE_POL  = 0;
    localparam int LANE_EDGE = 8;
    localparam int LANE_BOTH = 16;
    localparam int LANE_MASK = 8;

    typedef struct packed {
        logic       plain;
        logic       masked;
        logic [2:0] idx;
    } reg_hit_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] sync_o,
    output logic [NUM_PINS-1:0] prev_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0] prev;
        logic [1:0]          age;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_in;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
        if (s_q.age != 2'd3) begin
            s_d.age = s_q.age + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.sync;
    assign prev_o = s_q.prev;

    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.age == 2'd3) |-> (sync_o == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_masked,
    input  logic [2:0]          wr_idx,
    input  logic [23:0]         wr_data,
    output logic [NUM_PINS-1:0] cnf_o,
    output logic [NUM_PINS-1:0] oe_o,
    output logic [NUM_PINS-1:0] out_o,
    output logic [NUM_PINS-1:0] enb_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] edg_o,
    output logic [NUM_PINS-1:0] both_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] cnf;
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] enb;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] edg;
        logic [NUM_PINS-1:0] both;
    } cfg_t;

    cfg_t c_d, c_q;

    logic [NUM_PINS-1:0] wr_mask;
    logic [NUM_PINS-1:0] wr_val;
    assign wr_mask = wr_data[LANE_MASK +: NUM_PINS];
    assign wr_val  = wr_data[LANE_POL  +: NUM_PINS];

    function automatic logic [NUM_PINS-1:0] merge(
        input logic [NUM_PINS-1:0] old_v,
        input logic [NUM_PINS-1:0] msk,
        input logic [NUM_PINS-1:0] val
    );
        return (old_v & ~msk) | (val & msk);
    endfunction

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            case (wr_idx)
                IDX_CNF: c_d.cnf = wr_masked ? merge(c_q.cnf, wr_mask, wr_val) : wr_val;
                IDX_OE:  c_d.oe  = wr_masked ? merge(c_q.oe,  wr_mask, wr_val) : wr_val;
                IDX_OUT: c_d.out = wr_masked ? merge(c_q.out, wr_mask, wr_val) : wr_val;
                IDX_ENB: c_d.enb = wr_masked ? merge(c_q.enb, wr_mask, wr_val) : wr_val;
                IDX_LVL: begin
                    if (wr_masked) begin
                        c_d.pol = merge(c_q.pol, wr_mask, wr_val);
                    end else begin
                        c_d.pol  = wr_data[LANE_POL  +: NUM_PINS];
                        c_d.edg  = wr_data[LANE_EDGE +: NUM_PINS];
                        c_d.both = wr_data[LANE_BOTH +: NUM_PINS];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnf_o  = c_q.cnf;
    assign oe_o   = c_q.oe;
    assign out_o  = c_q.out;
    assign enb_o  = c_q.enb;
    assign pol_o  = c_q.pol;
    assign edg_o  = c_q.edg;
    assign both_o = c_q.both;

    // R3
    masked_out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_masked && wr_idx == IDX_OUT)
        |=> ((out_o & ~$past(wr_mask)) == ($past(out_o) & ~$past(wr_mask))));

    // R3
    masked_lvl_edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_masked && wr_idx == IDX_LVL) |=> ($stable(edg_o) && $stable(both_o)));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [NUM_PINS-1:0] prev_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic [NUM_PINS-1:0] edg_i,
    input  logic [NUM_PINS-1:0] both_i,
    input  logic [NUM_PINS-1:0] clr_i,
    input  logic                sta_we,
    input  logic [NUM_PINS-1:0] sta_wmask,
    input  logic [NUM_PINS-1:0] sta_wval,
    output logic [NUM_PINS-1:0] sta_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] sta;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_PINS-1:0] ev;
    logic [NUM_PINS-1:0] hit;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        logic rise, fall;
        assign rise    = sync_i[gi] & ~prev_i[gi];
        assign fall    = ~sync_i[gi] & prev_i[gi];
        assign ev[gi]  = edg_i[gi] & (both_i[gi] ? (rise | fall)
                                                 : (pol_i[gi] ? rise : fall));
        assign hit[gi] = (sync_i[gi] == pol_i[gi]);

        // R7
        edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edg_i[gi] && clr_i[gi] && !ev[gi] && !sta_we) |=> !sta_o[gi]);

        // R8
        edge_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edg_i[gi] && ev[gi]) |=> sta_o[gi]);

        // R9
        level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!edg_i[gi] && clr_i[gi] && (sync_i[gi] == pol_i[gi])) |=> sta_o[gi]);
    end

    always_comb begin
        logic b;
        st_d = st_q;
        b    = 1'b0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (edg_i[n]) begin
                b = st_q.sta[n];
                if (clr_i[n]) begin
                    b = 1'b0;
                end
                if (sta_we && sta_wmask[n]) begin
                    b = sta_wval[n];
                end
                st_d.sta[n] = b | ev[n];
            end else begin
                st_d.sta[n] = hit[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sta_o = st_q.sta;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int          NUM_PINS = 8,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] MASK_OFS = 12'h080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                port_irq
);
    localparam int PAGE_LSB = 7;
    localparam logic [ADDR_W-1:PAGE_LSB] MASK_PAGE = MASK_OFS[ADDR_W-1:PAGE_LSB];

    logic [NUM_PINS-1:0] sync_v, prev_v;
    logic [NUM_PINS-1:0] cnf_v, oe_v, out_v, enb_v, pol_v, edg_v, both_v, sta_v;
    logic [NUM_PINS-1:0] clr_v;
    logic [NUM_PINS-1:0] sta_wmask;
    logic                sta_we;
    logic                cfg_we;
    logic [7:0]          wdata_unused;
    reg_hit_t            hit_d;

    assign wdata_unused = reg_wdata[31:24];

    // address decode
    always_comb begin
        hit_d        = '0;
        hit_d.idx    = reg_addr[6:4];
        if (reg_addr[3:0] == 4'h0) begin
            if (reg_addr[ADDR_W-1:PAGE_LSB] == '0) begin
                hit_d.plain = 1'b1;
            end else if (reg_addr[ADDR_W-1:PAGE_LSB] == MASK_PAGE) begin
                hit_d.masked = (hit_d.idx != IDX_IN) && (hit_d.idx != IDX_CLR);
            end
        end
    end

    assign cfg_we    = reg_we && (hit_d.plain || hit_d.masked);
    assign sta_we    = cfg_we && (hit_d.idx == IDX_STA);
    assign sta_wmask = hit_d.masked ? reg_wdata[LANE_MASK +: NUM_PINS] : '1;
    assign clr_v     = (reg_we && hit_d.plain && hit_d.idx == IDX_CLR)
                     ? reg_wdata[NUM_PINS-1:0] : '0;

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_masked (hit_d.masked),
        .wr_idx    (hit_d.idx),
        .wr_data   (reg_wdata[23:0]),
        .cnf_o     (cnf_v),
        .oe_o      (oe_v),
        .out_o     (out_v),
        .enb_o     (enb_v),
        .pol_o     (pol_v),
        .edg_o     (edg_v),
        .both_o    (both_v)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS)) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_v),
        .prev_i    (prev_v),
        .pol_i     (pol_v),
        .edg_i     (edg_v),
        .both_i    (both_v),
        .clr_i     (clr_v),
        .sta_we    (sta_we),
        .sta_wmask (sta_wmask),
        .sta_wval  (reg_wdata[NUM_PINS-1:0]),
        .sta_o     (sta_v)
    );

    // read mux: only the plain page reads back
    always_comb begin
        reg_rdata = '0;
        if (hit_d.plain) begin
            case (hit_d.idx)
                IDX_CNF: reg_rdata[NUM_PINS-1:0] = cnf_v;
                IDX_OE:  reg_rdata[NUM_PINS-1:0] = oe_v;
                IDX_OUT: reg_rdata[NUM_PINS-1:0] = out_v;
                IDX_IN:  reg_rdata[NUM_PINS-1:0] = sync_v;
                IDX_STA: reg_rdata[NUM_PINS-1:0] = sta_v;
                IDX_ENB: reg_rdata[NUM_PINS-1:0] = enb_v;
                IDX_LVL: begin
                    reg_rdata[LANE_POL  +: NUM_PINS] = pol_v;
                    reg_rdata[LANE_EDGE +: NUM_PINS] = edg_v;
                    reg_rdata[LANE_BOTH +: NUM_PINS] = both_v;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    assign pin_out  = out_v;
    assign pin_oe   = cnf_v & oe_v;
    assign port_irq = |(sta_v & enb_v);

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enb_v == '0) |-> !port_irq);

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_v == '0) |-> !port_irq);

    // R4
    oe_needs_cnf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |-> (cnf_v[0] && $past(reg_we)));
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  pin_out, pin_oe;
    logic        port_irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [11:0] A_CNF = 12'h000, A_OE = 12'h010, A_OUT = 12'h020,
                            A_IN  = 12'h030, A_STA = 12'h040, A_ENB = 12'h050,
                            A_LVL = 12'h060, A_CLR = 12'h070, A_MSK = 12'h080;

    always #2 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_irq(port_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks are entered and left at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  m;
        logic [2:0]  codes [5];
        codes[0] = 3'b011; codes[1] = 3'b010; codes[2] = 3'b110;
        codes[3] = 3'b001; codes[4] = 3'b000;

        // R1: reset values
        step(3);
        for (int a = 0; a < 8; a++) begin
            rd(12'(a * 16), d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R1 reset pin_oe", {24'h0, pin_oe}, 32'h0);
        chk("R1 reset irq", {31'h0, port_irq}, 32'h0);
        rst_n = 1'b1;
        step(4);

        // R2: plain round trip and zero reads
        wr(A_CNF, 32'h12); rd(A_CNF, d); chk("R2 cnf", d, 32'h12);
        wr(A_OE, 32'h34);  rd(A_OE, d);  chk("R2 oe", d, 32'h34);
        wr(A_OUT, 32'h56); rd(A_OUT, d); chk("R2 out", d, 32'h56);
        wr(A_ENB, 32'h78); rd(A_ENB, d); chk("R2 enb", d, 32'h78);
        wr(A_LVL, 32'hFFABCDEF); rd(A_LVL, d); chk("R2 lvl", d, 32'h00ABCDEF);
        wr(A_LVL, 32'h0); wr(A_ENB, 32'h0);
        rd(A_CLR, d); chk("R2 clr reads zero", d, 32'h0);
        rd(A_MSK + A_OUT, d); chk("R2 masked alias reads zero", d, 32'h0);
        rd(12'h0F0, d); chk("R2 unmapped 0xF0", d, 32'h0);
        rd(12'h100, d); chk("R2 unmapped 0x100", d, 32'h0);
        wr(12'h100, 32'hFF); rd(A_CNF, d); chk("R2 unmapped write ignored", d, 32'h12);

        // R3: masked write sweep on output value, one pin at a time
        wr(A_OUT, 32'h3C);
        m = 8'h3C;
        for (int n = 0; n < 8; n++) begin
            for (int v = 0; v < 2; v++) begin
                wr(A_MSK + A_OUT, (32'h100 << n) | (32'(v) << n));
                m[n] = v[0];
                chk("R3 masked out pin", {24'h0, pin_out}, {24'h0, m});
            end
        end
        wr(A_MSK + A_CNF, 32'h0F0F); rd(A_CNF, d); chk("R3 masked cnf", d, 32'h1F);
        wr(A_MSK + A_ENB, 32'hC040); rd(A_ENB, d); chk("R3 masked enb", d, 32'h40);
        wr(A_ENB, 32'h0);
        wr(A_LVL, 32'h00AA00); wr(A_MSK + A_LVL, 32'hFFFF55);
        rd(A_LVL, d); chk("R3 masked lvl polarity only", d, 32'h00AA55);
        wr(A_LVL, 32'h0);

        // R4: enable sweep
        wr(A_OE, 32'hA5);
        for (int c = 0; c < 256; c++) begin
            wr(A_CNF, 32'(c));
            chk("R4 pin_oe", {24'h0, pin_oe}, 32'(c) & 32'hA5);
        end
        wr(A_OUT, 32'h96); chk("R4 pin_out", {24'h0, pin_out}, 32'h96);
        wr(A_CNF, 32'h0);

        // R5: two-stage input sync
        pin_in = 8'hC3;
        step(1); rd(A_IN, d); chk("R5 in after one edge", d, 32'hFF);
        step(1); rd(A_IN, d); chk("R5 in after two edges", d, 32'hC3);
        pin_in = 8'hFF; step(4);

        // R6 / R7 / R9: every trigger code on pin 3
        for (int t = 0; t < 5; t++) begin
            logic pol, edg, both, e0;
            pol = codes[t][0]; edg = codes[t][1]; both = codes[t][2];
            pin_in = 8'hF7; step(4);
            wr(A_LVL, (32'(both) << 19) | (32'(edg) << 11) | (32'(pol) << 3));
            wr(A_CLR, 32'h08);
            e0 = edg ? 1'b0 : !pol;
            rd(A_STA, d); chk("R6 R9 pin3 low after clear", (d >> 3) & 1, 32'(e0));
            pin_in = 8'hFF;
            step(2); rd(A_STA, d); chk("R6 status not yet due", (d >> 3) & 1, 32'(e0));
            step(1); rd(A_STA, d);
            chk("R6 rise", (d >> 3) & 1, 32'(edg ? (both | pol) : pol));
            wr(A_CLR, 32'h08); rd(A_STA, d);
            chk("R7 R9 clear after rise", (d >> 3) & 1, 32'(edg ? 1'b0 : pol));
            pin_in = 8'hF7; step(3); rd(A_STA, d);
            chk("R6 fall", (d >> 3) & 1, 32'(edg ? (both | !pol) : !pol));
        end

        // R8: edge in same cycle as clear, then re-arm after clear
        wr(A_LVL, 32'h000808);
        pin_in = 8'hF7; step(4);
        wr(A_CLR, 32'h08); rd(A_STA, d); chk("R8 cleared", (d >> 3) & 1, 32'h0);
        pin_in = 8'hFF; step(2);
        wr(A_CLR, 32'h08);
        rd(A_STA, d); chk("R8 edge wins over clear", (d >> 3) & 1, 32'h1);
        wr(A_CLR, 32'h08); rd(A_STA, d); chk("R7 clear", (d >> 3) & 1, 32'h0);
        pin_in = 8'hF7; step(4); rd(A_STA, d); chk("R8 falling ignored", (d >> 3) & 1, 32'h0);
        pin_in = 8'hFF; step(3); rd(A_STA, d); chk("R8 re-armed", (d >> 3) & 1, 32'h1);

        // R9: level high, clear while active
        wr(A_LVL, 32'h000008); step(1);
        wr(A_CLR, 32'h08); rd(A_STA, d); chk("R9 clear ignored while active", (d >> 3) & 1, 32'h1);
        pin_in = 8'hF7; step(3); rd(A_STA, d); chk("R9 level drop", (d >> 3) & 1, 32'h0);

        // R11 / R7: software status writes on edge pins
        wr(A_LVL, 32'h00FFFF); step(1);
        wr(A_CLR, 32'hFF);
        wr(A_STA, 32'h81); rd(A_STA, d); chk("R11 plain status write", d, 32'h81);
        wr(A_MSK + A_STA, 32'h0100); rd(A_STA, d); chk("R11 masked clear bit0", d, 32'h80);
        wr(A_MSK + A_STA, 32'h0202); rd(A_STA, d); chk("R11 masked set bit1", d, 32'h82);
        wr(A_CLR, 32'h80); rd(A_STA, d); chk("R7 clear bit7", d, 32'h02);
        wr(A_CLR, 32'h00); rd(A_STA, d); chk("R7 zero clear no effect", d, 32'h02);

        // R10: enable sweep against a fixed level status
        wr(A_LVL, 32'h0000FF);
        pin_in = 8'h5A; step(3);
        rd(A_STA, d); chk("R9 level status pattern", d, 32'h5A);
        for (int e = 0; e < 256; e++) begin
            wr(A_ENB, 32'(e));
            chk("R10 irq", {31'h0, port_irq}, {31'h0, |(8'(e) & 8'h5A)});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule